// File: doc/BRIEF.md
# Capture Timer (16-bit, down-counting)

This block is a 16-bit down-counter with a reload latch. In every mode the counter reloads itself from the latch when it underflows and raises a one-cycle underflow interrupt pulse. A slow count strobe from a clock divider outside the block drives the count. A single input pin adds three further behaviours, picked by a 2-bit mode field:

- **Event counting:** the counter counts edges on the pin instead of strobes.
- **Period measurement:** one chosen pin edge reloads the counter.
- **Continuous high/low measurement:** both pin edges reload the counter.

A reload caused by a pin edge also captures the counter value from just before the reload. The capture is held for readback until software has read the full 16-bit value once.

Software uses the block through a small byte-wide register port. There are three registers: the low byte, the high byte and a control byte. A write to either data byte updates the reload latch. A 16-bit read is done low byte first. Reading the low byte freezes a copy of the high byte, so the two halves belong to the same value even if the counter moves between the reads. The pin passes through a two-stage synchronizer before edge detection.

The capture-hold controller is a small state machine with three named states:

- **HOLD_IDLE:** readback shows the live counter.
- **HOLD_FULL:** a capture is waiting to be read.
- **HOLD_LOW_SEEN:** the low byte of the capture has been read.

Its transitions are:

- **CAPTURE:** any state moves to HOLD_FULL on an edge reload.
- **READ_LOW:** HOLD_FULL moves to HOLD_LOW_SEEN on a low-byte read.
- **READ_HIGH:** HOLD_LOW_SEEN moves to HOLD_IDLE on a high-byte read.

Top module: `capture_timer16`

## Requirements
- R1: After reset the control byte reads 0x00, the counter and the reload latch both hold 0xFFFF, and both interrupt outputs are low.
- R2: Register addresses are 0 for the low byte, 1 for the high byte and 2 for control. The control byte holds the mode in bits 1:0 (00 timer, 01 period, 10 event, 11 high/low), the edge select in bit 2 and the stop bit in bit 3. Bits 7:4 read as 0.
- R3: In timer mode each strobe decrements the counter. A strobe that finds the counter at 0 instead reloads it from the latch and pulses `uf_irq` high for one cycle. With latch value n, underflows are therefore n+1 strobes apart.
- R4: While the stop bit is 1, strobes and counting edges leave the counter unchanged.
- R5: A write to a data byte while the stop bit is 1 loads the new latch value into the counter as well. While the stop bit is 0, such a write changes only the latch.
- R6: In period mode, one pin edge reloads the counter from the latch, captures the counter's prior value and pulses `edge_irq`. That edge is falling when edge select is 0 and rising when it is 1. The opposite edge has no effect on the counter or on `edge_irq`.
- R7: In event mode the counter decrements on rising pin edges (edge select 0) or falling pin edges (edge select 1), and count strobes are ignored.
- R8: In high/low mode both pin edges reload, capture and pulse `edge_irq`, whatever the edge select bit says.
- R9: After an edge reload, 16-bit reads return the captured value until one low-then-high read completes. Later reads return the live counter.
- R10: A low-byte read freezes the high byte of the same value, and a later high-byte read returns that frozen byte even if the counter has changed meanwhile.
- R11: When a reloading pin edge and an underflow occur in the same cycle, the counter takes the edge reload, the capture holds the pre-reload value, and both `uf_irq` and `edge_irq` pulse.
- R12: A pin change takes effect on the third rising clock edge after it is applied, because of the two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_tick | input | 1 | Count strobe from the external divider, one cycle wide |
| meas_in | input | 1 | Asynchronous measurement/event pin |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe (has side effects on the low and high bytes) |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |
| uf_irq | output | 1 | One-cycle pulse on counter underflow |
| edge_irq | output | 1 | One-cycle pulse on an interrupting pin edge |

## Verification
The hardest case to reach from the ports is a pin edge that is detected in the same cycle as an underflow. The bench gets there by first running the counter down to zero. It then drops the pin and counts the two synchronizer stages, so that the final count strobe is issued in exactly the cycle the edge is detected. The second hard case is coherency of the split read. For that, the bench issues a count strobe in the same cycle as the low-byte read, so the counter crosses a high-byte boundary between the two reads.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

    typedef enum logic [1:0] {
        MODE_TIMER  = 2'b00,
        MODE_PERIOD = 2'b01,
        MODE_EVENT  = 2'b10,
        MODE_HILO   = 2'b11
    } tmode_e;

    typedef enum logic [1:0] {
        HOLD_IDLE     = 2'd0,
        HOLD_FULL     = 2'd1,
        HOLD_LOW_SEEN = 2'd2
    } hold_e;

    localparam int REG_ADDR_W = 2;
    localparam logic [REG_ADDR_W-1:0] ADDR_LO  = 2'd0;
    localparam logic [REG_ADDR_W-1:0] ADDR_HI  = 2'd1;
    localparam logic [REG_ADDR_W-1:0] ADDR_CTL = 2'd2;

endpackage

// File: rtl/ctmr_edge.sv
module ctmr_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= pin;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[TOP];
    end

    assign rise = sync_q[TOP] & ~prev_q;
    assign fall = ~sync_q[TOP] & prev_q;

    // R12
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

    // R12
    fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/ctmr_count.sv
module ctmr_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic             edge_rld,
    input  logic             load_now,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] latch_val,
    output logic [CNT_W-1:0] cnt,
    output logic             uf_pulse
);
    logic [CNT_W-1:0] cnt_q;
    logic             uf_q;
    logic             underflow;

    assign underflow = count_en && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '1;
            uf_q  <= 1'b0;
        end else begin
            uf_q <= underflow;
            if (load_now)
                cnt_q <= load_val;
            else if (edge_rld)
                cnt_q <= latch_val;
            else if (underflow)
                cnt_q <= latch_val;
            else if (count_en)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt      = cnt_q;
    assign uf_pulse = uf_q;

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_en && !edge_rld && !load_now) |=> $stable(cnt_q));

    // R3
    uf_from_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uf_q |-> ($past(cnt_q) == '0));

    // R11
    edge_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_rld && !load_now) |=> (cnt_q == $past(latch_val)));

endmodule

// File: rtl/ctmr_capture.sv
module ctmr_capture
    import ctmr_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_ev,
    input  logic [2*BYTE_W-1:0] cnt,
    input  logic                rd_lo,
    input  logic                rd_hi,
    output logic [BYTE_W-1:0]   view_lo,
    output logic [BYTE_W-1:0]   hi_snap
);
    localparam int CNT_W = 2 * BYTE_W;

    hold_e            state_q, state_d;
    logic [CNT_W-1:0] cap_q;
    logic [BYTE_W-1:0] hi_q;
    logic [CNT_W-1:0] view;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HOLD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (cap_ev) begin
            state_d = HOLD_FULL;
        end else begin
            unique case (state_q)
                HOLD_IDLE:     state_d = HOLD_IDLE;
                HOLD_FULL:     if (rd_lo) state_d = HOLD_LOW_SEEN;
                HOLD_LOW_SEEN: if (rd_hi) state_d = HOLD_IDLE;
                default:       state_d = HOLD_IDLE;
            endcase
        end
    end

    always_comb begin
        view = (state_q == HOLD_IDLE) ? cnt : cap_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
            hi_q  <= '0;
        end else begin
            if (cap_ev) cap_q <= cnt;
            if (rd_lo)  hi_q  <= view[CNT_W-1:BYTE_W];
        end
    end

    assign view_lo = view[BYTE_W-1:0];
    assign hi_snap = hi_q;

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != HOLD_IDLE) && !cap_ev) |=> $stable(cap_q));

    // R9
    capture_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_ev |=> (cap_q == $past(cnt)));

    // R10
    snap_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_lo |=> $stable(hi_q));

endmodule

// File: rtl/capture_timer16.sv
module capture_timer16
    import ctmr_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cnt_tick,
    input  logic                  meas_in,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0]     wr_data,
    input  logic                  rd_en,
    input  logic [REG_ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0]     rd_data,
    output logic                  uf_irq,
    output logic                  edge_irq
);
    localparam int CNT_W = 2 * BYTE_W;

    tmode_e           mode_q;
    logic             esel_q;
    logic             stop_q;
    logic [CNT_W-1:0] latch_q, latch_d;
    logic             edge_irq_q;

    logic             pin_rise, pin_fall;
    logic             irq_edge, cnt_edge, measuring;
    logic             edge_rld, count_en, load_now;
    logic             wr_lo, wr_hi, wr_ctl;
    logic [CNT_W-1:0] cnt;
    logic [BYTE_W-1:0] view_lo, hi_snap;
    logic             rd_lo, rd_hi;

    ctmr_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (meas_in),
        .rise (pin_rise),
        .fall (pin_fall)
    );

    assign wr_lo  = wr_en && (wr_addr == ADDR_LO);
    assign wr_hi  = wr_en && (wr_addr == ADDR_HI);
    assign wr_ctl = wr_en && (wr_addr == ADDR_CTL);
    assign rd_lo  = rd_en && (rd_addr == ADDR_LO);
    assign rd_hi  = rd_en && (rd_addr == ADDR_HI);

    always_comb begin
        latch_d = latch_q;
        if (wr_lo) latch_d[BYTE_W-1:0]     = wr_data;
        if (wr_hi) latch_d[CNT_W-1:BYTE_W] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '1;
            mode_q  <= MODE_TIMER;
            esel_q  <= 1'b0;
            stop_q  <= 1'b0;
        end else begin
            latch_q <= latch_d;
            if (wr_ctl) begin
                mode_q <= tmode_e'(wr_data[1:0]);
                esel_q <= wr_data[2];
                stop_q <= wr_data[3];
            end
        end
    end

    always_comb begin
        unique case (mode_q)
            MODE_HILO: irq_edge = pin_rise | pin_fall;
            default:   irq_edge = esel_q ? pin_rise : pin_fall;
        endcase
        cnt_edge  = esel_q ? pin_fall : pin_rise;
        measuring = (mode_q == MODE_PERIOD) || (mode_q == MODE_HILO);
        edge_rld  = measuring && irq_edge;
        if (stop_q)
            count_en = 1'b0;
        else if (mode_q == MODE_EVENT)
            count_en = cnt_edge;
        else
            count_en = cnt_tick;
        load_now = stop_q && (wr_lo || wr_hi);
    end

    ctmr_count #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (count_en),
        .edge_rld (edge_rld),
        .load_now (load_now),
        .load_val (latch_d),
        .latch_val(latch_q),
        .cnt      (cnt),
        .uf_pulse (uf_irq)
    );

    ctmr_capture #(.BYTE_W(BYTE_W)) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_ev (edge_rld),
        .cnt    (cnt),
        .rd_lo  (rd_lo),
        .rd_hi  (rd_hi),
        .view_lo(view_lo),
        .hi_snap(hi_snap)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) edge_irq_q <= 1'b0;
        else        edge_irq_q <= irq_edge;
    end
    assign edge_irq = edge_irq_q;

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_LO:  rd_data = view_lo;
            ADDR_HI:  rd_data = hi_snap;
            ADDR_CTL: rd_data[3:0] = {stop_q, esel_q, mode_q};
            default:  rd_data = '0;
        endcase
    end

    // R6
    edge_irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_irq_q |-> $past(pin_rise || pin_fall));

    // R7
    event_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_EVENT && !pin_rise && !pin_fall && !load_now) |=> $stable(cnt));

endmodule

// File: tb/capture_timer16_bench.sv
module capture_timer16_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_tick = 1'b0;
    logic       meas_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       uf_irq, edge_irq;

    int n_chk = 0;
    int n_bad = 0;
    int uf_seen, edge_seen;

    always #4 clk = ~clk;

    capture_timer16 u_capture_timer16 (
        .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .meas_in(meas_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .uf_irq(uf_irq), .edge_irq(edge_irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); rd_en = 1'b1; rd_addr = a; #1 d = rd_data;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic rd16(output int v);
        logic [7:0] lo, hi;
        rd(2'd0, lo);
        rd(2'd1, hi);
        v = {hi, lo};
    endtask

    task automatic ticks(input int n);
        uf_seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); cnt_tick = 1'b1;
            @(negedge clk); cnt_tick = 1'b0;
            if (uf_irq) uf_seen++;
        end
    endtask

    task automatic set_pin(input logic v);
        @(negedge clk); meas_in = v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        edge_seen = edge_irq;
        uf_seen = uf_irq;
    endtask

    task automatic load_stopped(input logic [1:0] mode, input logic esel, input int val);
        wr(2'd2, {4'b0, 1'b1, esel, mode});
        wr(2'd0, val[7:0]);
        wr(2'd1, val[15:8]);
        wr(2'd2, {4'b0, 1'b0, esel, mode});
    endtask

    task automatic t_reset;
        int v; logic [7:0] c;
        rd(2'd2, c);
        check("R1 ctrl", c, 8'h00);
        rd16(v);
        check("R1 counter", v, 16'hFFFF);
        check("R1 irqs", {uf_irq, edge_irq}, 0);
    endtask

    task automatic t_ctrl;
        logic [7:0] c;
        wr(2'd2, 8'hFD);
        rd(2'd2, c);
        check("R2 ctrl readback", c, 8'h0D);
        wr(2'd2, 8'h08);
    endtask

    task automatic t_timer;
        int v;
        load_stopped(2'b00, 1'b0, 16'h0003);
        ticks(3);
        rd16(v);
        check("R3 count after 3", v, 0);
        check("R3 no early uf", uf_seen, 0);
        ticks(1);
        check("R3 uf at n+1", uf_seen, 1);
        rd16(v);
        check("R3 reload", v, 3);
    endtask

    task automatic t_stop;
        int v;
        wr(2'd2, 8'h08);
        ticks(4);
        rd16(v);
        check("R4 stopped", v, 3);
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h40);
        rd16(v);
        check("R5 running write latch only", v, 3);
        ticks(4);
        rd16(v);
        check("R5 new latch on reload", v, 16'h0040);
    endtask

    task automatic t_period;
        int v;
        load_stopped(2'b01, 1'b0, 16'h0010);
        set_pin(1'b1);
        check("R6 wrong edge no irq", edge_seen, 0);
        rd16(v);
        check("R6 wrong edge no reload", v, 16'h0010);
        ticks(5);
        set_pin(1'b0);
        check("R6 edge irq", edge_seen, 1);
        ticks(3);
        rd16(v);
        check("R9 held capture", v, 16'h000B);
        rd16(v);
        check("R9 released to live", v, 16'h000D);
    endtask

    task automatic t_period_rise;
        int v;
        load_stopped(2'b01, 1'b1, 16'h0030);
        ticks(2);
        set_pin(1'b1);
        check("R6 rising edge irq", edge_seen, 1);
        rd16(v);
        check("R6 rising capture", v, 16'h002E);
        ticks(1);
        set_pin(1'b0);
        check("R6 falling ignored irq", edge_seen, 0);
        rd16(v);
        check("R6 falling ignored cnt", v, 16'h002F);
    endtask

    task automatic t_event;
        int v;
        load_stopped(2'b10, 1'b0, 16'h0002);
        ticks(3);
        rd16(v);
        check("R7 ticks ignored", v, 2);
        set_pin(1'b1);
        rd16(v);
        check("R7 rise counts", v, 1);
        set_pin(1'b0);
        rd16(v);
        check("R7 fall ignored", v, 1);
        set_pin(1'b1);
        set_pin(1'b0);
        set_pin(1'b1);
        check("R7 underflow on edge", uf_seen, 1);
        rd16(v);
        check("R7 reload", v, 2);
        set_pin(1'b0);
    endtask

    task automatic t_hilo;
        int v;
        load_stopped(2'b11, 1'b1, 16'h0020);
        ticks(4);
        set_pin(1'b1);
        check("R8 rise irq", edge_seen, 1);
        rd16(v);
        check("R8 rise capture", v, 16'h001C);
        ticks(6);
        set_pin(1'b0);
        check("R8 fall irq", edge_seen, 1);
        rd16(v);
        check("R8 fall capture", v, 16'h001A);
    endtask

    task automatic t_coincide;
        int v;
        set_pin(1'b1);
        load_stopped(2'b01, 1'b0, 16'h0002);
        ticks(2);
        @(negedge clk); meas_in = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk); cnt_tick = 1'b1;
        @(negedge clk); cnt_tick = 1'b0;
        check("R11 both irqs", {uf_irq, edge_irq}, 2'b11);
        rd16(v);
        check("R11 capture pre-reload", v, 0);
        rd16(v);
        check("R11 edge reload value", v, 2);
    endtask

    task automatic t_split_read;
        logic [7:0] lo, hi; int v;
        load_stopped(2'b00, 1'b0, 16'h0100);
        @(negedge clk); rd_en = 1'b1; rd_addr = 2'd0; cnt_tick = 1'b1; #1 lo = rd_data;
        @(negedge clk); cnt_tick = 1'b0; rd_addr = 2'd1; #1 hi = rd_data;
        @(negedge clk); rd_en = 1'b0;
        check("R10 coherent value", {hi, lo}, 16'h0100);
        rd16(v);
        check("R10 live after", v, 16'h00FF);
    endtask

    initial begin
        #1500000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_ctrl();
        t_timer();
        t_stop();
        t_period();
        t_period_rise();
        t_event();
        t_hilo();
        t_coincide();
        t_split_read();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule